// File: doc/BRIEF.md
# I2C Master Byte Transmit Engine

This block is the transmit side of an I2C bus master. A host drives it through a small register-style port. It issues a Start condition on request. Each host write of a byte then clocks eight bits out on SDA, most significant bit first, so an address byte carries seven address bits followed by the read/write bit. After the eighth bit the engine lets go of SDA, clocks a ninth pulse and records whether the slave pulled SDA low. It raises an interrupt flag and parks the bus with SCL held low and its timer halted. The transfer then waits until the host writes another byte or asks for a Repeated Start or a Stop.

Both bus lines are open drain. The engine only reports when it pulls a line low. The bus level of SDA comes back on an input, which is used to sample the acknowledge. Every SCL phase (low or high) and every step of a bus condition lasts one bit period of `reload + 1` system clocks. A small phase counter sets this period, and it reloads at every phase change. When SCL falls, SDA changes one system clock later, so the data has a hold time after the falling edge.

The status flags are buffer-full, write-collision, acknowledge-status and interrupt. Write-collision and interrupt are sticky. The host clears them by writing zero to them through the status write strobe.

Top module: `i2c_tx_engine`

## Requirements
- R1: After reset neither bus line is pulled low, every status flag and every request flag reads 0, and the bus stays quiet with no SCL activity until a request arrives.
- R2: A byte write while the bus is parked sets buffer-full on the next clock and starts shifting at once. The byte goes out most significant bit first, one bit per SCL pulse, followed by a ninth acknowledge pulse.
- R3: During a byte, every SCL low phase and every SCL high phase lasts exactly reload+1 system clocks.
- R4: During a byte, SDA changes only while SCL is low, one system clock after SCL falls. It never changes while SCL is high.
- R5: Buffer-full is still 1 at the seventh SCL falling edge and is 0 from the eighth falling edge on. From that edge on, the engine releases SDA for the acknowledge.
- R6: The SDA level sampled at the end of the ninth SCL high phase is stored as ack-status: 0 when the slave pulled SDA low (acknowledge) and 1 when SDA was high (no acknowledge).
- R7: When the ninth SCL falls, the interrupt flag sets. SCL then stays pulled low, SDA stays released and no further SCL pulse occurs until the next host action.
- R8: A byte write at any time other than while parked changes nothing on the bus and leaves the byte in flight unchanged, and it sets the write-collision flag. Such times are while a byte shifts, while a condition is running, and while the bus is idle.
- R9: A status write clears write-collision or interrupt only when the value written for that flag is 0. A value of 1 leaves the flag as it was.
- R10: A start request while idle sets the start flag. SDA falls while SCL is high, then SCL is pulled low. On completion the start flag self-clears, the interrupt flag sets and the bus is parked with both lines low.
- R11: A restart request while parked releases SDA and then SCL, pulls SDA low while SCL is high, and then pulls SCL low. The restart flag reads 1 until completion, when it clears and the interrupt flag sets.
- R12: A stop request while parked pulls SDA low, releases SCL, then releases SDA while SCL is high. The stop flag reads 1 until completion, when it clears, the interrupt flag sets and both lines are left released.
- R13: Start, restart and stop requests that arrive while a byte is shifting are ignored: no request flag sets and no condition follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | RW (8) | Bit-period reload value; each phase lasts reload+1 clocks |
| wr_buf | input | 1 | One-clock strobe writing the transmit byte |
| wr_data | input | DW (8) | Byte to transmit |
| req_start | input | 1 | One-clock Start request |
| req_restart | input | 1 | One-clock Repeated Start request |
| req_stop | input | 1 | One-clock Stop request |
| stat_wr | input | 1 | One-clock status write strobe |
| stat_wcol_in | input | 1 | Value written to write-collision (0 clears) |
| stat_irq_in | input | 1 | Value written to interrupt (0 clears) |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bf | output | 1 | Buffer-full flag |
| wcol | output | 1 | Write-collision flag (sticky) |
| ackstat | output | 1 | Last acknowledge status (1 = no acknowledge) |
| irq | output | 1 | Interrupt flag (sticky) |
| sen | output | 1 | Start in progress |
| rsen | output | 1 | Repeated Start in progress |
| pen | output | 1 | Stop in progress |

## Verification
The embedded properties assume that `reload` is at least 1 and does not change while the phase counter runs. They also assume that requests and writes are single-clock strobes and that `sda_in` follows the bus level in step with `sda_oe`. The bench changes `reload` only while the bus is parked and pulses every host input for exactly one clock. It plays the slave on SDA only inside the acknowledge slot, which starts after the eighth falling edge. The bench never drives SCL, so the stimulus never calls for clock stretching or arbitration.

// File: rtl/i2c_txe_pkg.sv
package i2c_txe_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ST1, S_ST2, S_PARK, S_BLO, S_BHI,
        S_RS1, S_RS2, S_RS3, S_RS4, S_SP1, S_SP2, S_SP3
    } seq_state_e;

    // States in which the engine holds SCL low
    function automatic logic scl_low_in(seq_state_e s);
        return (s == S_ST2) || (s == S_PARK) || (s == S_BLO) ||
               (s == S_RS1) || (s == S_RS4)  || (s == S_SP1);
    endfunction

endpackage

// File: rtl/i2c_txe_baud.sv
module i2c_txe_baud #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q >= reload);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the phase counter advances by one each clock until the terminal count
    assert_phase_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: the count never passes the reload value while running
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= reload));

endmodule

// File: rtl/i2c_txe_core.sv
module i2c_txe_core
    import i2c_txe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_buf,
    input  logic [DW-1:0] wr_data,
    input  logic          req_start,
    input  logic          req_restart,
    input  logic          req_stop,
    input  logic          stat_wr,
    input  logic          stat_wcol_in,
    input  logic          stat_irq_in,
    input  logic          sda_in,
    output logic          run,
    output logic          scl_low,
    output logic          sda_low,
    output logic          bf,
    output logic          wcol,
    output logic          ackst,
    output logic          irq,
    output logic          sen,
    output logic          rsen,
    output logic          pen
);
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] ACK_IDX = BCW'(DW);

    typedef struct packed {
        seq_state_e     st;
        logic [BCW-1:0] bitn;
        logic [DW-1:0]  sh;
        logic           bf;
        logic           wcol;
        logic           ackst;
        logic           irq;
        logic           sen;
        logic           rsen;
        logic           pen;
        logic           scl_low;
        logic           sda_low;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    assign run = !((seq_q.st == S_IDLE) || (seq_q.st == S_PARK));

    always_comb begin
        seq_d = seq_q;
        // host clears first, hardware sets afterwards so a set wins
        if (stat_wr) begin
            if (!stat_wcol_in) seq_d.wcol = 1'b0;
            if (!stat_irq_in)  seq_d.irq  = 1'b0;
        end
        if (wr_buf && (seq_q.st != S_PARK)) seq_d.wcol = 1'b1;

        case (seq_q.st)
            S_IDLE: if (req_start) begin seq_d.st = S_ST1; seq_d.sen = 1'b1; end
            S_ST1:  if (tick) seq_d.st = S_ST2;
            S_ST2:  if (tick) begin seq_d.st = S_PARK; seq_d.sen = 1'b0; seq_d.irq = 1'b1; end
            S_PARK: begin
                if (wr_buf) begin
                    seq_d.st   = S_BLO;
                    seq_d.sh   = wr_data;
                    seq_d.bitn = '0;
                    seq_d.bf   = 1'b1;
                end else if (req_restart) begin
                    seq_d.st = S_RS1; seq_d.rsen = 1'b1;
                end else if (req_stop) begin
                    seq_d.st = S_SP1; seq_d.pen = 1'b1;
                end
            end
            S_BLO:  if (tick) seq_d.st = S_BHI;
            S_BHI: begin
                if (tick) begin
                    if (seq_q.bitn == ACK_IDX) begin
                        seq_d.ackst = sda_in;
                        seq_d.irq   = 1'b1;
                        seq_d.st    = S_PARK;
                    end else begin
                        seq_d.st   = S_BLO;
                        seq_d.sh   = {seq_q.sh[DW-2:0], 1'b0};
                        seq_d.bitn = seq_q.bitn + 1'b1;
                        if (seq_q.bitn == ACK_IDX - 1'b1) seq_d.bf = 1'b0;
                    end
                end
            end
            S_RS1:  if (tick) seq_d.st = S_RS2;
            S_RS2:  if (tick) seq_d.st = S_RS3;
            S_RS3:  if (tick) seq_d.st = S_RS4;
            S_RS4:  if (tick) begin seq_d.st = S_PARK; seq_d.rsen = 1'b0; seq_d.irq = 1'b1; end
            S_SP1:  if (tick) seq_d.st = S_SP2;
            S_SP2:  if (tick) seq_d.st = S_SP3;
            S_SP3:  if (tick) begin seq_d.st = S_IDLE; seq_d.pen = 1'b0; seq_d.irq = 1'b1; end
            default: seq_d.st = S_IDLE;
        endcase

        // SCL follows the next state; SDA follows the current one, so it
        // lags SCL by one clock and gives hold time after each falling edge
        seq_d.scl_low = scl_low_in(seq_d.st);
        case (seq_q.st)
            S_ST1, S_ST2, S_RS3, S_RS4, S_SP1, S_SP2: seq_d.sda_low = 1'b1;
            S_BLO, S_BHI: seq_d.sda_low = (seq_q.bitn != ACK_IDX) && !seq_q.sh[DW-1];
            S_PARK:       seq_d.sda_low = seq_q.sda_low;
            default:      seq_d.sda_low = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scl_low = seq_q.scl_low;
    assign sda_low = seq_q.sda_low;
    assign bf      = seq_q.bf;
    assign wcol    = seq_q.wcol;
    assign ackst   = seq_q.ackst;
    assign irq     = seq_q.irq;
    assign sen     = seq_q.sen;
    assign rsen    = seq_q.rsen;
    assign pen     = seq_q.pen;

    // R4: data on SDA holds still through an SCL high phase
    assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_BHI && !tick) |=> $stable(seq_q.sda_low));

    // R5: during the acknowledge slot the buffer is empty and SDA released
    assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_BHI && seq_q.bitn == ACK_IDX) |-> (!seq_q.bf && !seq_q.sda_low));

    // R7: a rising interrupt outside idle leaves SCL pulled low
    assert_park_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seq_q.irq) && seq_q.st != S_IDLE) |-> seq_q.scl_low);

    // R8: collision flag stays set until the host writes 0 to it
    assert_wcol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.wcol && !(stat_wr && !stat_wcol_in)) |=> seq_q.wcol);

    // R12: stop completion leaves both lines released
    assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_SP3 && tick) |=> (!seq_q.scl_low && !seq_q.sda_low));

    // R13: at most one condition flag at a time, and requests do not alter them mid-byte
    assert_req_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_q.sen, seq_q.rsen, seq_q.pen}));
    assert_req_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == S_BLO || seq_q.st == S_BHI) && (req_start || req_restart || req_stop))
        |=> $stable({seq_q.sen, seq_q.rsen, seq_q.pen}));

endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine #(
    parameter int DW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload,
    input  logic          wr_buf,
    input  logic [DW-1:0] wr_data,
    input  logic          req_start,
    input  logic          req_restart,
    input  logic          req_stop,
    input  logic          stat_wr,
    input  logic          stat_wcol_in,
    input  logic          stat_irq_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          bf,
    output logic          wcol,
    output logic          ackstat,
    output logic          irq,
    output logic          sen,
    output logic          rsen,
    output logic          pen
);
    logic run, tick;

    i2c_txe_baud #(.RW(RW)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (reload),
        .tick   (tick)
    );

    i2c_txe_core #(.DW(DW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_buf       (wr_buf),
        .wr_data      (wr_data),
        .req_start    (req_start),
        .req_restart  (req_restart),
        .req_stop     (req_stop),
        .stat_wr      (stat_wr),
        .stat_wcol_in (stat_wcol_in),
        .stat_irq_in  (stat_irq_in),
        .sda_in       (sda_in),
        .run          (run),
        .scl_low      (scl_oe),
        .sda_low      (sda_oe),
        .bf           (bf),
        .wcol         (wcol),
        .ackst        (ackstat),
        .irq          (irq),
        .sen          (sen),
        .rsen         (rsen),
        .pen          (pen)
    );

endmodule

// File: tb/i2c_tx_engine_test.sv
module i2c_tx_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // each entry: {reload[7:0], slave_ack, byte[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'd3, 1'b1, 8'hA5},
        {8'd3, 1'b0, 8'h3C},
        {8'd1, 1'b1, 8'hFF},
        {8'd5, 1'b0, 8'h00},
        {8'd2, 1'b1, 8'h81}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rl = 8'd3;
    logic wr_buf = 0, req_start = 0, req_restart = 0, req_stop = 0;
    logic stat_wr = 0, stat_wcol_in = 1, stat_irq_in = 1;
    logic [7:0] wr_data = 8'h00;
    logic pull = 0;
    logic sda_in;
    logic scl_oe, sda_oe, bf, wcol, ackstat, irq, sen, rsen, pen;

    int errors = 0, checks = 0, cyc = 0;
    // monitor state
    logic mon_byte = 0, ack_now = 0, scl_p = 1, sda_p = 1, bf7 = 0, bf8 = 1;
    logic [8:0] cap = '0;
    int rises = 0, hi_len = 0, lo_len = 0, len_err = 0, glitch = 0, starts = 0, stops = 0;

    assign sda_in = !(sda_oe || pull);

    i2c_tx_engine uut (
        .clk(clk), .rst_n(rst_n), .reload(rl), .wr_buf(wr_buf), .wr_data(wr_data),
        .req_start(req_start), .req_restart(req_restart), .req_stop(req_stop),
        .stat_wr(stat_wr), .stat_wcol_in(stat_wcol_in), .stat_irq_in(stat_irq_in),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .bf(bf), .wcol(wcol),
        .ackstat(ackstat), .irq(irq), .sen(sen), .rsen(rsen), .pen(pen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // bus monitor, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic scl_l, sda_l;
            scl_l = !scl_oe;
            sda_l = sda_in;
            if (scl_l && !scl_p) begin
                if (mon_byte) begin
                    if (rises > 0 && lo_len != rl + 1) len_err++;
                    cap = {cap[7:0], sda_l};
                    rises++;
                end
                hi_len = 0;
            end
            if (!scl_l && scl_p) begin
                if (mon_byte && hi_len != rl + 1) len_err++;
                if (mon_byte && rises == 7) bf7 = bf;
                if (mon_byte && rises == 8) begin bf8 = bf; pull = ack_now; end
                lo_len = 0;
            end
            if (scl_l) hi_len++; else lo_len++;
            if (scl_l && scl_p && sda_l != sda_p) begin
                if (mon_byte) glitch++;
                else if (!sda_l) starts++;
                else stops++;
            end
            if (!mon_byte) pull = 0;
            scl_p = scl_l;
            sda_p = sda_l;
        end
    end

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic wait_irq(input string what);
        int n = 0;
        while (!irq && n < 4000) begin step(); n++; end
        chk(irq == 1'b1, what, 32'(irq), 1);
    endtask

    task automatic stat_write(input logic wc, input logic iq);
        stat_wr = 1; stat_wcol_in = wc; stat_irq_in = iq;
        step();
        stat_wr = 0; stat_wcol_in = 1; stat_irq_in = 1;
    endtask

    task automatic send_byte(input logic [7:0] dat, input logic ack, input logic [7:0] rv);
        rl = rv; ack_now = ack; cap = '0; rises = 0; len_err = 0; glitch = 0;
        bf7 = 0; bf8 = 1; mon_byte = 1;
        wr_buf = 1; wr_data = dat;
        step();
        wr_buf = 0;
        chk(bf == 1'b1, "R2 buffer-full after write", 32'(bf), 1);
        wait_irq("R7 interrupt after ninth clock");
        chk(ackstat == !ack, "R6 ack-status", 32'(ackstat), 32'(!ack));
        chk(scl_oe && !sda_oe && !bf, "R7 parked SCL low, SDA released",
            {29'd0, scl_oe, sda_oe, bf}, 32'b100);
        repeat (12) step();
        chk(cap[8:1] == dat, "R2 byte shifted MSB first", 32'(cap[8:1]), 32'(dat));
        chk(rises == 9 && scl_oe, "R7 clock suspended after ninth pulse", rises, 9);
        chk(len_err == 0, "R3 phase length reload+1", len_err, 0);
        chk(glitch == 0, "R4 SDA stable while SCL high", glitch, 0);
        chk(bf7 && !bf8, "R5 buffer-full drops at eighth fall", {30'd0, bf7, bf8}, 32'b10);
        mon_byte = 0;
        stat_write(1'b1, 1'b0);
        chk(irq == 1'b0, "R9 interrupt cleared by writing 0", 32'(irq), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        chk({scl_oe, sda_oe, bf, wcol, ackstat, irq, sen, rsen, pen} == '0,
            "R1 reset flags and lines", {23'd0, scl_oe, sda_oe, bf, wcol, ackstat, irq, sen, rsen, pen}, 0);
        repeat (20) step();
        chk(!scl_oe && starts == 0, "R1 bus quiet after reset", 32'(scl_oe), 0);

        // R8: write while idle collides; R9: write of 1 keeps, write of 0 clears
        wr_buf = 1; wr_data = 8'h5A; step(); wr_buf = 0;
        chk(wcol == 1'b1 && !scl_oe && !bf, "R8 write while idle collides", 32'(wcol), 1);
        stat_write(1'b1, 1'b1);
        chk(wcol == 1'b1, "R9 writing 1 leaves collision set", 32'(wcol), 1);
        stat_write(1'b0, 1'b1);
        chk(wcol == 1'b0, "R9 writing 0 clears collision", 32'(wcol), 0);

        // R10: Start
        req_start = 1; step(); req_start = 0;
        chk(sen == 1'b1, "R10 start flag set", 32'(sen), 1);
        wait_irq("R10 interrupt after start");
        chk(!sen && scl_oe && sda_oe, "R10 start self-clears, lines low", {29'd0, sen, scl_oe, sda_oe}, 32'b011);
        chk(starts == 1, "R10 SDA fell while SCL high", starts, 1);
        stat_write(1'b1, 1'b0);

        // table walk: R2..R7
        for (int i = 0; i < NVEC; i++) send_byte(VEC[i][7:0], VEC[i][8], VEC[i][16:9]);

        // R8 collision mid-byte and R13 ignored requests
        rl = 8'd3; ack_now = 1; cap = '0; rises = 0; bf7 = 0; bf8 = 1; mon_byte = 1;
        wr_buf = 1; wr_data = 8'hC6; step(); wr_buf = 0;
        while (rises < 3) step();
        wr_buf = 1; wr_data = 8'h11; step(); wr_buf = 0;
        chk(wcol == 1'b1, "R8 write during shift sets collision", 32'(wcol), 1);
        req_stop = 1; req_restart = 1; req_start = 1; step();
        req_stop = 0; req_restart = 0; req_start = 0;
        chk({sen, rsen, pen} == 3'b000, "R13 requests ignored mid-byte", {29'd0, sen, rsen, pen}, 0);
        wait_irq("R7 interrupt after collided byte");
        repeat (12) step();
        chk(cap[8:1] == 8'hC6, "R8 byte in flight unchanged", 32'(cap[8:1]), 32'hC6);
        chk(stops == 0 && scl_oe && {sen, rsen, pen} == 3'b000, "R13 no condition followed", stops, 0);
        mon_byte = 0;
        stat_write(1'b0, 1'b0);
        chk(!wcol && !irq, "R9 both flags cleared", {30'd0, wcol, irq}, 0);

        // R11: Repeated Start
        req_restart = 1; step(); req_restart = 0;
        chk(rsen == 1'b1, "R11 restart flag set", 32'(rsen), 1);
        wait_irq("R11 interrupt after restart");
        chk(!rsen && scl_oe && sda_oe, "R11 restart clears, parked low", {29'd0, rsen, scl_oe, sda_oe}, 32'b011);
        chk(starts == 2 && stops == 0, "R11 start condition on bus", starts, 2);
        stat_write(1'b1, 1'b0);
        send_byte(8'h92, 1'b0, 8'd2);

        // R12: Stop
        req_stop = 1; step(); req_stop = 0;
        chk(pen == 1'b1, "R12 stop flag set", 32'(pen), 1);
        wait_irq("R12 interrupt after stop");
        chk(!pen && !scl_oe && !sda_oe, "R12 stop clears, lines released", {29'd0, pen, scl_oe, sda_oe}, 0);
        chk(stops == 1, "R12 SDA rose while SCL high", stops, 1);
        stat_write(1'b1, 1'b0);
        wr_buf = 1; wr_data = 8'h01; step(); wr_buf = 0;
        repeat (8) step();
        chk(wcol && !scl_oe, "R8 write after stop collides, bus idle", {30'd0, wcol, scl_oe}, 32'b10);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule